// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is a register-driven I2C master that only transmits. Software first puts the destination byte in the data register: a 7-bit slave address in bits 7:1, with bit 0 cleared to mark a write. It then sets the enable bit and writes the start command. The engine then does the following on its own:

- drives a START condition;
- shifts the byte out MSB first on eight SCL clocks;
- releases SDA for a ninth, acknowledge clock and latches the bit the slave returns there;
- pulses an interrupt.

The SCL lines are then parked low. Each further write to the data register sends one more byte with its own acknowledge clock. A stop command either ends the transfer at once, when the engine is parked, or is armed and takes effect as soon as the byte in flight completes.

A clock configuration register selects the SCL rate and the acknowledge check. Each SCL bit is four equal phases of Q system clocks. Q is Q_STD for standard rate (100 kHz) and Q_FAST for fast rate (400 kHz). When the acknowledge check is on, a byte that is not acknowledged locks the engine until software issues a stop. The engine also stops on such a byte if a stop was already armed.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, scl_o and sda_o are high, irq_o is low, and all four registers read zero. The register addresses are: 0 data, 1 command/status, 2 control, 3 clock configuration. While not busy, both lines stay high.
- R2: Writing 1 to bit 0 of register 1 while bit 0 of register 2 (enable) is set produces a START condition: SDA falls while SCL is high. The byte held in register 0 follows, and irq_o rises 40*Q+1 cycles after the clock edge that took the write.
- R3: Each byte is sent MSB first on eight SCL rising edges, followed by a ninth acknowledge clock with sda_o released high. Every SCL bit lasts 4*Q cycles.
- R4: While the engine is parked between bytes, a write to register 0 starts that byte with no other command. irq_o rises 36*Q+1 cycles after the clock edge that took the write.
- R5: irq_o is a single-cycle pulse, given once per byte, right after the acknowledge clock.
- R6: The SDA level at the ninth SCL rising edge is latched and reads as bit 1 of register 1: 0 for acknowledge, 1 for no acknowledge.
- R7: Writing 1 to bit 1 of register 1 during a byte arms a stop, which reads as bit 2 of register 1. A STOP condition (SDA rises while SCL is high) then follows that byte, and busy (bit 0 of register 1) falls 4*Q cycles after that byte's irq. The same write while parked begins the STOP at once, and busy falls 4*Q+1 cycles after the write edge.
- R8: With the acknowledge check on (bit 1 of register 3), a byte that is not acknowledged and has no stop armed leaves the engine parked. Data writes are then ignored (no SCL clocks, no irq) until a stop command. With the check off, an unacknowledged byte does not block the next data write.
- R9: Bit 0 of register 3 selects fast rate, which uses Q = Q_FAST instead of Q_STD. The register reads back as written.
- R10: A start command is ignored while the enable bit is clear: busy stays low and SCL does not toggle.
- R11: While a data bit is on the bus, sda_o changes only while scl_o is low. SDA moves with SCL high only at START and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| sda_i | input | 1 | Sensed SDA level from the bus |
| scl_o | output | 1 | SCL level driven toward the bus (1 = released) |
| sda_o | output | 1 | SDA level driven toward the bus (1 = released) |
| irq_o | output | 1 | Byte-complete interrupt pulse |

## Verification
A write is taken at clock edge E, and the resulting command acts one edge later. From that, the irq pulse is due at E+1+40Q for a start and at E+1+36Q for a parked data write. Busy falls at E+1+4Q for a stop issued while parked, and 4Q edges after the irq for an armed stop. The bench counts clock edges and records the edge of each write. It observes outputs on the falling clock edge and compares the observed edge number exactly against these sums, computed from Q for the selected rate. A bus monitor on the same falling edges decodes START, STOP, byte values and the acknowledge level from the SCL and SDA waveforms. The bench sweeps every byte value from 0 to 255 at standard rate, and the lock and rate cases at fast rate.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_HOLD,
    ST_STOP
  } seq_state_t;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_CMD  = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_CFG  = 2'd3;

  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_HALT_BIT = 1;
  localparam int BYTE_W       = 8;
endpackage

// File: rtl/i2cx_regs.sv
module i2cx_regs
  import i2cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              busy,
  input  logic              last_bit,
  input  logic              armed,
  output logic              en,
  output logic              fast,
  output logic              ackchk,
  output logic [BYTE_W-1:0] data,
  output logic              start_req,
  output logic              stop_req,
  output logic              byte_req
);
  logic wr_data, wr_cmd, wr_ctrl, wr_cfg;

  assign wr_data = we && (addr == RA_DATA);
  assign wr_cmd  = we && (addr == RA_CMD);
  assign wr_ctrl = we && (addr == RA_CTRL);
  assign wr_cfg  = we && (addr == RA_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data      <= '0;
      en        <= 1'b0;
      fast      <= 1'b0;
      ackchk    <= 1'b0;
      start_req <= 1'b0;
      stop_req  <= 1'b0;
      byte_req  <= 1'b0;
    end else begin
      start_req <= wr_cmd && wdata[CMD_GO_BIT];
      stop_req  <= wr_cmd && wdata[CMD_HALT_BIT];
      byte_req  <= wr_data;
      if (wr_data) data <= wdata;
      if (wr_ctrl) en <= wdata[0];
      if (wr_cfg) begin
        fast   <= wdata[0];
        ackchk <= wdata[1];
      end
    end
  end

  always_comb begin
    unique case (addr)
      RA_DATA: rdata = data;
      RA_CMD:  rdata = {5'b0, armed, last_bit, busy};
      RA_CTRL: rdata = {7'b0, en};
      default: rdata = {6'b0, ackchk, fast};
    endcase
  end
endmodule

// File: rtl/i2cx_clkdiv.sv
module i2cx_clkdiv #(
  parameter int Q_STD  = 312,
  parameter int Q_FAST = 78
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int QMAX = (Q_STD > Q_FAST) ? Q_STD : Q_FAST;
  localparam int CW   = $clog2(QMAX) + 1;
  localparam logic [CW-1:0] LIM_S = CW'(Q_STD - 1);
  localparam logic [CW-1:0] LIM_F = CW'(Q_FAST - 1);

  logic [CW-1:0] cnt, cnt_n, lim;

  assign lim  = fast ? LIM_F : LIM_S;
  assign tick = run && (cnt == lim);

  always_comb begin
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/i2cx_seq.sv
module i2cx_seq
  import i2cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              ackchk,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              byte_req,
  input  logic [BYTE_W-1:0] data,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              irq,
  output logic              busy,
  output logic              last_bit,
  output logic              armed,
  output logic              run,
  output logic              bit_active
);
  localparam logic [3:0] ACK_IDX = 4'(BYTE_W);

  seq_state_t        st, st_n;
  logic [1:0]        ph, ph_n;
  logic [3:0]        bitn, bit_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              arm_n, lock, lock_n, lb_n, irq_n;

  always_comb begin
    st_n   = st;
    ph_n   = ph;
    bit_n  = bitn;
    sh_n   = sh;
    arm_n  = armed;
    lock_n = lock;
    lb_n   = last_bit;
    irq_n  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start_req && en) begin
          st_n   = ST_START;
          ph_n   = 2'd0;
          sh_n   = data;
          arm_n  = 1'b0;
          lock_n = 1'b0;
        end
      end
      ST_START: begin
        if (stop_req) arm_n = 1'b1;
        if (tick) begin
          ph_n = ph + 2'd1;
          if (ph == 2'd3) begin
            st_n  = ST_BIT;
            bit_n = 4'd0;
          end
        end
      end
      ST_BIT: begin
        if (stop_req) arm_n = 1'b1;
        if (tick) begin
          ph_n = ph + 2'd1;
          if (ph == 2'd1 && bitn == ACK_IDX) lb_n = sda_i;
          if (ph == 2'd3) begin
            if (bitn == ACK_IDX) begin
              irq_n = 1'b1;
              if (arm_n) begin
                st_n = ST_STOP;
              end else begin
                st_n   = ST_HOLD;
                lock_n = ackchk && last_bit;
              end
            end else begin
              bit_n = bitn + 4'd1;
              sh_n  = {sh[BYTE_W-2:0], 1'b0};
            end
          end
        end
      end
      ST_HOLD: begin
        if (stop_req) begin
          st_n = ST_STOP;
          ph_n = 2'd0;
        end else if (byte_req && !lock) begin
          st_n  = ST_BIT;
          ph_n  = 2'd0;
          bit_n = 4'd0;
          sh_n  = data;
        end
      end
      ST_STOP: begin
        if (tick) begin
          ph_n = ph + 2'd1;
          if (ph == 2'd3) begin
            st_n   = ST_IDLE;
            arm_n  = 1'b0;
            lock_n = 1'b0;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= 2'd0;
      bitn     <= 4'd0;
      sh       <= '0;
      armed    <= 1'b0;
      lock     <= 1'b0;
      last_bit <= 1'b0;
      irq      <= 1'b0;
    end else begin
      st       <= st_n;
      ph       <= ph_n;
      bitn     <= bit_n;
      sh       <= sh_n;
      armed    <= arm_n;
      lock     <= lock_n;
      last_bit <= lb_n;
      irq      <= irq_n;
    end
  end

  always_comb begin
    unique case (st)
      ST_START: begin scl_o = (ph != 2'd3); sda_o = (ph == 2'd0); end
      ST_BIT:   begin scl_o = ph[1]; sda_o = (bitn == ACK_IDX) ? 1'b1 : sh[BYTE_W-1]; end
      ST_HOLD:  begin scl_o = 1'b0; sda_o = 1'b0; end
      ST_STOP:  begin scl_o = (ph != 2'd0); sda_o = ph[1]; end
      default:  begin scl_o = 1'b1; sda_o = 1'b1; end
    endcase
  end

  assign busy       = (st != ST_IDLE);
  assign run        = (st == ST_START) || (st == ST_BIT) || (st == ST_STOP);
  assign bit_active = (st == ST_BIT);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cx_pkg::*;
#(
  parameter int Q_STD  = 312,
  parameter int Q_FAST = 78
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_o,
  output logic       irq_o
);
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic              en_w, fast_w, ackchk_w, start_w, stop_w, byte_w;
  logic              busy_w, last_w, armed_w, run_w, bit_act_w, tick_w;
  logic [BYTE_W-1:0] data_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  i2cx_regs u_regs (
    .clk(clk), .rst_n(rst_q_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy_w),
    .last_bit(last_w), .armed(armed_w), .en(en_w), .fast(fast_w),
    .ackchk(ackchk_w), .data(data_w), .start_req(start_w),
    .stop_req(stop_w), .byte_req(byte_w)
  );

  i2cx_clkdiv #(.Q_STD(Q_STD), .Q_FAST(Q_FAST)) u_div (
    .clk(clk), .rst_n(rst_q_n), .run(run_w), .fast(fast_w), .tick(tick_w)
  );

  i2cx_seq u_seq (
    .clk(clk), .rst_n(rst_q_n), .tick(tick_w), .en(en_w),
    .ackchk(ackchk_w), .start_req(start_w), .stop_req(stop_w),
    .byte_req(byte_w), .data(data_w), .sda_i(sda_i), .scl_o(scl_o),
    .sda_o(sda_o), .irq(irq_o), .busy(busy_w), .last_bit(last_w),
    .armed(armed_w), .run(run_w), .bit_active(bit_act_w)
  );
endmodule

// File: rtl/i2cx_checker.sv
module i2cx_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_o,
  input logic sda_o,
  input logic irq_o,
  input logic busy,
  input logic bit_active
);
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && sda_o));

  p_sda_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_active && $past(bit_active) && scl_o && $past(scl_o)) |-> $stable(sda_o));

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_irq_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(scl_o) && $past(bit_active)));

  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(scl_o) && $past(sda_o)));
endmodule

bind i2c_byte_master i2cx_checker u_chk (
  .clk(clk), .rst_n(rst_q_n), .scl_o(scl_o), .sda_o(sda_o),
  .irq_o(irq_o), .busy(busy_w), .bit_active(bit_act_w)
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  localparam int QS = 3;
  localparam int QF = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       we;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       scl, sda, sda_in, irq;
  logic       slave_drive, slave_nack;

  int nvec = 0, nerr = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_in = sda & ~slave_drive;

  i2c_byte_master #(.Q_STD(QS), .Q_FAST(QF)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .sda_i(sda_in),
    .scl_o(scl), .sda_o(sda), .irq_o(irq)
  );

  // bus monitor and acknowledging slave
  logic       p_scl = 1'b1, p_sda = 1'b1;
  int         mcnt = 0, nbytes = 0, nstart = 0, nstop = 0, nrise = 0;
  logic [7:0] mshift = 8'h00;
  logic [7:0] rx_byte [0:511];
  logic       rx_ack  [0:511];

  always @(negedge clk) begin
    logic ln;
    ln = sda_in;
    if (rst_n) begin
      if (p_scl && scl && p_sda && !ln) begin nstart++; mcnt = 0; end
      else if (p_scl && scl && !p_sda && ln) nstop++;
      if (!p_scl && scl) begin
        nrise++;
        if (mcnt == 8) begin
          rx_byte[nbytes] = mshift;
          rx_ack[nbytes]  = ln;
          nbytes++;
          mcnt = 0;
        end else begin
          mshift = {mshift[6:0], ln};
          mcnt++;
        end
      end
      if (!scl) slave_drive = (mcnt == 8) && !slave_nack;
    end
    p_scl = scl;
    p_sda = ln;
  end

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int t);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    t = cyc;
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_irq(output int t);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!irq && guard < 5000);
    if (!irq) check("R5 irq timeout", 0, 1);
    t = cyc;
  endtask

  task automatic wait_idle(output int t);
    int guard = 0;
    addr = 2'd1;
    do begin
      @(negedge clk);
      guard++;
    end while (rdata[0] && guard < 5000);
    t = cyc;
  endtask

  initial begin
    #(8 * 190000);
    nvec++; nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int t0, t1, t2, nb, nr;
    logic [7:0] d;
    rst_n = 1'b0; we = 1'b0; addr = 2'd0; wdata = 8'h00;
    slave_nack = 1'b0; slave_drive = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 scl", scl, 1);
    check("R1 sda", sda, 1);
    check("R1 irq", irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reg zero", d, 0);
    end

    // R9 configuration readback: standard rate, ack check on
    wr(2'd3, 8'h02, t0);
    rd(2'd3, d);
    check("R9 cfg readback", d, 2);
    wr(2'd2, 8'h01, t0);

    // R2 start with address byte
    wr(2'd0, 8'hA4, t0);
    wr(2'd1, 8'h01, t0);
    wait_irq(t1);
    check("R2 start irq latency", t1 - t0, 40 * QS + 1);
    check("R2 start seen", nstart, 1);
    check("R3 address byte", rx_byte[0], 8'hA4);
    @(negedge clk);
    check("R5 irq single cycle", irq, 0);
    rd(2'd1, d);
    check("R6 ack latched", d[1], 0);
    check("R7 busy while parked", d[0], 1);

    // R3 R4 sweep of every byte value at standard rate
    for (int b = 0; b < 256; b++) begin
      wr(2'd0, 8'(b), t0);
      wait_irq(t1);
      check("R4 data irq latency", t1 - t0, 36 * QS + 1);
      check("R3 byte value", rx_byte[b + 1], b);
      check("R6 ack on bus", rx_ack[b + 1], 0);
    end
    check("R3 rising edges", nrise, 9 * 257);

    // R7 armed stop during a byte
    wr(2'd0, 8'h3C, t0);
    wr(2'd1, 8'h02, t0);
    rd(2'd1, d);
    check("R7 stop armed flag", d[2], 1);
    wait_irq(t1);
    wait_idle(t2);
    check("R7 armed stop latency", t2 - t1, 4 * QS);
    check("R7 stop seen", nstop, 1);
    check("R3 last byte", rx_byte[257], 8'h3C);
    check("R1 idle scl", scl, 1);

    // R9 fast rate; R8 lock on missing ack
    wr(2'd3, 8'h03, t0);
    slave_nack = 1'b1;
    wr(2'd0, 8'h96, t0);
    wr(2'd1, 8'h01, t0);
    wait_irq(t1);
    check("R9 fast start latency", t1 - t0, 40 * QF + 1);
    rd(2'd1, d);
    check("R6 nack latched", d[1], 1);
    nr = nrise; nb = nbytes;
    wr(2'd0, 8'h11, t0);
    repeat (60 * QF) begin
      @(negedge clk);
      if (irq) check("R8 irq while locked", 1, 0);
    end
    check("R8 no clocks while locked", nrise, nr);
    check("R8 no byte while locked", nbytes, nb);
    wr(2'd1, 8'h02, t0);
    wait_idle(t2);
    check("R7 parked stop latency", t2 - t0, 4 * QF + 1);
    check("R7 second stop", nstop, 2);

    // R8 ack check off: missing ack does not block
    wr(2'd3, 8'h01, t0);
    wr(2'd0, 8'h5A, t0);
    wr(2'd1, 8'h01, t0);
    wait_irq(t1);
    wr(2'd0, 8'hC3, t0);
    wait_irq(t1);
    check("R8 unchecked nack continues", t1 - t0, 36 * QF + 1);
    check("R8 byte after nack", rx_byte[nbytes - 1], 8'hC3);
    wr(2'd1, 8'h02, t0);
    wait_idle(t2);
    slave_nack = 1'b0;

    // R10 start ignored while disabled
    wr(2'd2, 8'h00, t0);
    nr = nrise;
    wr(2'd1, 8'h01, t0);
    repeat (20) @(negedge clk);
    rd(2'd1, d);
    check("R10 busy stays low", d[0], 0);
    check("R10 no clocks", nrise, nr);
    check("R10 scl high", scl, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule